// File: doc/BRIEF.md
# Migrating Bank-Set Cache Controller

This block controls a small cache whose ways sit in banks at different distances from the requester. Each of the sets is spread across all of the banks, with one way per bank. Way 0 is the nearest bank and the last way is the farthest. A response comes back after a fixed core bank time plus a hop delay for each step of distance. When the controller runs in migrating mode, a line that hits moves one bank closer to the requester by trading places with the line in the next-nearer way. Lines that are used often therefore collect in the fast banks, and new lines enter at the far end.

The controller takes one request at a time on a valid/ready port. The request carries an address, a read/write flag and write data. The response is a single-cycle pulse that carries the data, a hit flag and the way that served the access. A mode input selects a fixed placement instead of migration. In that mode a line's bank is chosen by its address alone and lines never move. The tag and data arrays are register arrays inside the block, and a miss installs the line without fetching anything from a lower level.

Top module: `nuca_bankset_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, and every line is invalid, so the first access to any address misses.
- R2: The set index is req_addr[2:0] and the tag is req_addr[7:3]. A line is found only in the set its index selects.
- R3: When a request is accepted at clock edge 0 and served by way k, resp_valid is 1 in the cycle after edge 3+2k and is 1 for exactly that one cycle. A miss is served by the way that receives the new line.
- R4: req_ready is 0 from the accept edge through the response cycle, and returns to 1 in the cycle after resp_valid.
- R5: On a read hit, resp_hit is 1, resp_way gives the way that holds the line, and resp_data is the stored data. At most one way matches.
- R6: In migrating mode (static_mode=0), a hit in way k>0 exchanges that line with the line in way k-1 after the response. The next access finds the line in way k-1 and the displaced line in way k.
- R7: In migrating mode, a hit in way 0 moves nothing.
- R8: In migrating mode, a miss installs the line in way 3 and evicts whatever way 3 held. Ways 0 to 2 are unchanged. A read miss returns resp_hit=0, resp_way=3 and resp_data=0.
- R9: A write returns its own write data on resp_data. A write hit replaces the line's data before any move, and a write miss installs the line holding the write data.
- R10: In static mode (static_mode=1 at accept), a hit moves nothing and a miss installs the line in way tag[1:0].
- R11: A request presented while req_ready is 0 is ignored and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| static_mode | input | 1 | 1 selects address-fixed placement, 0 selects migration; sampled at accept |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | 8 | Tag in bits 7:3, set index in bits 2:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | 1 when the line was present |
| resp_way | output | 2 | Way that served the access |
| resp_data | output | 32 | Read data, or the write data for a write |

## Verification
A line's position is internal state, and the ports reveal it only through the latency of the next access to that line and through the resp_way value reported with it. If a swap is lost, or moves the wrong pair of lines, the fault shows on the very next access to either line as a way and a latency that are one bank step off. A fill into the wrong way, or a stray update to a set, shows as an unexpected hit or miss when a later access probes a line that should have been kept or evicted. The directed sequences therefore revisit each moved or displaced line right after the move.

// File: rtl/nuca_pkg.sv
package nuca_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } ctrl_state_e;

  // access time of a way: core bank time plus hop delay per step of distance
  function automatic int unsigned way_latency(input int unsigned way,
                                              input int unsigned base_cyc,
                                              input int unsigned hop_cyc);
    return base_cyc + hop_cyc * way;
  endfunction

  // bank that an address owns when placement is fixed
  function automatic int unsigned home_way(input int unsigned tag,
                                           input int unsigned ways);
    return tag % ways;
  endfunction

endpackage

// File: rtl/nuca_tag_lookup.sv
module nuca_tag_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 5,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             line_valid [WAYS],
  input  logic [TAG_W-1:0] line_tag   [WAYS],
  input  logic [TAG_W-1:0] probe_tag,
  output logic [WAYS-1:0]  match_vec,
  output logic             any_match,
  output logic [WAY_W-1:0] match_way
);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match_vec[g] = line_valid[g] && (line_tag[g] == probe_tag);
    end
  endgenerate

  assign any_match = |match_vec;

  always_comb begin
    match_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_vec[w]) match_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/nuca_latency_timer.sv
module nuca_latency_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign expire = run_q && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/nuca_line_store.sv
module nuca_line_store #(
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid [WAYS],
  output logic [TAG_W-1:0]  rd_tag   [WAYS],
  output logic [DATA_W-1:0] rd_data  [WAYS],
  input  logic [SET_W-1:0]  upd_set,
  input  logic              fill_en,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              swap_en,
  input  logic [WAY_W-1:0]  swap_way
);

  logic              v_q [SETS][WAYS];
  logic [TAG_W-1:0]  t_q [SETS][WAYS];
  logic [DATA_W-1:0] d_q [SETS][WAYS];

  logic              nv [WAYS];
  logic [TAG_W-1:0]  nt [WAYS];
  logic [DATA_W-1:0] nd [WAYS];
  logic [WAY_W-1:0]  near_way;
  logic              upd_any;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_rd
      assign rd_valid[g] = v_q[rd_set][g];
      assign rd_tag[g]   = t_q[rd_set][g];
      assign rd_data[g]  = d_q[rd_set][g];
    end
  endgenerate

  assign near_way = swap_way - WAY_W'(1);
  assign upd_any  = fill_en || wr_en || swap_en;

  // next contents of the updated row: fill, then data write, then exchange
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      nv[w] = v_q[upd_set][w];
      nt[w] = t_q[upd_set][w];
      nd[w] = d_q[upd_set][w];
    end
    if (fill_en) begin
      nv[fill_way] = 1'b1;
      nt[fill_way] = fill_tag;
      nd[fill_way] = fill_data;
    end
    if (wr_en) nd[wr_way] = wr_data;
    if (swap_en && (swap_way != '0)) begin
      nv[swap_way] = v_q[upd_set][near_way];
      nt[swap_way] = t_q[upd_set][near_way];
      nd[swap_way] = d_q[upd_set][near_way];
      nv[near_way] = v_q[upd_set][swap_way];
      nt[near_way] = t_q[upd_set][swap_way];
      nd[near_way] = wr_en ? wr_data : d_q[upd_set][swap_way];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) v_q[s][w] <= 1'b0;
    end else if (upd_any) begin
      for (int w = 0; w < WAYS; w++) v_q[upd_set][w] <= nv[w];
    end
  end

  always_ff @(posedge clk) begin
    if (upd_any) begin
      for (int w = 0; w < WAYS; w++) begin
        t_q[upd_set][w] <= nt[w];
        d_q[upd_set][w] <= nd[w];
      end
    end
  end

endmodule

// File: rtl/nuca_bankset_ctrl.sv
module nuca_bankset_ctrl #(
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BASE_LAT = 3,
  parameter int HOP_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              static_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [$clog2(WAYS)-1:0] resp_way,
  output logic [DATA_W-1:0] resp_data
);
  import nuca_pkg::*;

  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int TAG_W   = ADDR_W - SET_W;
  localparam int MAX_LAT = BASE_LAT + HOP_LAT * (WAYS - 1);
  localparam int CNT_W   = $clog2(MAX_LAT + 1) + 1;

  ctrl_state_e state_q;

  logic [SET_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic              row_valid [WAYS];
  logic [TAG_W-1:0]  row_tag   [WAYS];
  logic [DATA_W-1:0] row_data  [WAYS];
  logic [WAYS-1:0]   hit_vec;
  logic              lookup_hit;
  logic [WAY_W-1:0]  lookup_way;
  logic [WAY_W-1:0]  target_way;
  logic [DATA_W-1:0] early_data;
  logic [CNT_W-1:0]  target_lat;
  logic              timer_expire;

  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              mode_q;
  logic              hit_q;
  logic [WAY_W-1:0]  way_q;
  logic [DATA_W-1:0] data_q;

  // named internal events for the checker
  logic accept_evt;
  logic resp_evt;
  logic swap_evt;
  logic fill_evt;
  logic wr_evt;

  assign req_set = req_addr[SET_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:SET_W];

  nuca_line_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (req_set),
    .rd_valid  (row_valid),
    .rd_tag    (row_tag),
    .rd_data   (row_data),
    .upd_set   (set_q),
    .fill_en   (fill_evt),
    .fill_way  (way_q),
    .fill_tag  (tag_q),
    .fill_data (we_q ? wdata_q : '0),
    .wr_en     (wr_evt),
    .wr_way    (way_q),
    .wr_data   (wdata_q),
    .swap_en   (swap_evt),
    .swap_way  (way_q)
  );

  nuca_tag_lookup #(
    .WAYS(WAYS), .TAG_W(TAG_W)
  ) u_lookup (
    .line_valid (row_valid),
    .line_tag   (row_tag),
    .probe_tag  (req_tag),
    .match_vec  (hit_vec),
    .any_match  (lookup_hit),
    .match_way  (lookup_way)
  );

  // way serving the access: the holder on a hit, the receiver on a miss
  always_comb begin
    if (lookup_hit)
      target_way = lookup_way;
    else if (static_mode)
      target_way = WAY_W'(home_way(int'(req_tag), WAYS));
    else
      target_way = WAY_W'(WAYS - 1);
  end

  always_comb begin
    if (req_write)
      early_data = req_wdata;
    else if (lookup_hit)
      early_data = row_data[lookup_way];
    else
      early_data = '0;
  end

  assign target_lat = CNT_W'(way_latency(int'(target_way), BASE_LAT, HOP_LAT));

  nuca_latency_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept_evt),
    .load_val (target_lat),
    .expire   (timer_expire)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept_evt = req_valid && req_ready;
  assign resp_evt   = (state_q == ST_RESP);
  assign fill_evt   = resp_evt && !hit_q;
  assign wr_evt     = resp_evt && hit_q && we_q;
  assign swap_evt   = resp_evt && hit_q && !mode_q && (way_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_evt)   state_q <= ST_WAIT;
        ST_WAIT: if (timer_expire) state_q <= ST_RESP;
        ST_RESP:                   state_q <= ST_IDLE;
        default:                   state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= '0;
      tag_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      mode_q  <= 1'b0;
      hit_q   <= 1'b0;
      way_q   <= '0;
      data_q  <= '0;
    end else if (accept_evt) begin
      set_q   <= req_set;
      tag_q   <= req_tag;
      we_q    <= req_write;
      wdata_q <= req_wdata;
      mode_q  <= static_mode;
      hit_q   <= lookup_hit;
      way_q   <= target_way;
      data_q  <= early_data;
    end
  end

  assign resp_valid = resp_evt;
  assign resp_hit   = hit_q;
  assign resp_way   = way_q;
  assign resp_data  = data_q;

endmodule

// File: rtl/nuca_bankset_chk.sv
module nuca_bankset_chk #(
  parameter int WAYS     = 4,
  parameter int BASE_LAT = 3,
  parameter int HOP_LAT  = 2,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [WAY_W-1:0] resp_way,
  input logic             mode_q,
  input logic [WAYS-1:0]  hit_vec,
  input logic             accept_evt,
  input logic             swap_evt,
  input logic             fill_evt
);

  logic [7:0] since_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_accept <= '0;
    else if (accept_evt)         since_accept <= '0;
    else if (since_accept != '1) since_accept <= since_accept + 8'd1;
  end

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R3

  AST_LATENCY_BY_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (32'(since_accept) == BASE_LAT + HOP_LAT * 32'(resp_way))); // R3

  AST_BUSY_DURING_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready); // R4

  AST_READY_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> req_ready); // R4

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R5

  AST_SWAP_ON_FAR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> (resp_valid && resp_hit && (resp_way != '0))); // R6

  AST_NO_SWAP_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> !mode_q); // R10

  AST_FILL_FAR_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !mode_q) |-> (resp_way == WAY_W'(WAYS - 1))); // R8

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready); // R11

endmodule

bind nuca_bankset_ctrl nuca_bankset_chk #(
  .WAYS(WAYS), .BASE_LAT(BASE_LAT), .HOP_LAT(HOP_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_way   (resp_way),
  .mode_q     (mode_q),
  .hit_vec    (hit_vec),
  .accept_evt (accept_evt),
  .swap_evt   (swap_evt),
  .fill_evt   (fill_evt)
);

// File: tb/tb_nuca_bankset_ctrl.sv
module tb_nuca_bankset_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        static_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic        resp_hit;
  logic [1:0]  resp_way;
  logic [31:0] resp_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nuca_bankset_ctrl dut (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_way(resp_way), .resp_data(resp_data)
  );

  function automatic logic [7:0] mk(input int tag, input int idx);
    return {5'(tag), 3'(idx)};
  endfunction

  // expected response time of a way: 3 cycles at the nearest bank, 2 more per step out
  function automatic int exp_cycles(input int way);
    int t = 3;
    for (int s = 0; s < way; s++) t += 2;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one request; optionally offer a stray write while the controller is busy
  task automatic access(input string req, input logic [7:0] addr, input bit we,
                        input logic [31:0] wd, input bit stat,
                        input bit exp_hit, input int exp_way, input logic [31:0] exp_data,
                        input bit poke = 1'b0, input logic [7:0] poke_addr = '0);
    int j;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = we; req_wdata = wd; static_mode = stat;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    j = 0;
    while (!resp_valid && j < 40) begin
      if (poke && j == 1) begin
        req_valid = 1'b1; req_addr = poke_addr; req_write = 1'b1; req_wdata = 32'h99;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      j++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(resp_hit == exp_hit, req, "hit flag", resp_hit, exp_hit);
    check(int'(resp_way) == exp_way, req, "way", resp_way, exp_way);
    check(resp_data == exp_data, req, "data", resp_data, exp_data);
    check(j == exp_cycles(exp_way), "R3", "latency", j, exp_cycles(exp_way));
    check(!req_ready, "R4", "ready low at response", req_ready, 0);
    @(negedge clk);
    check(!resp_valid, "R3", "single-cycle response", resp_valid, 0);
    check(req_ready, "R4", "ready back after response", req_ready, 1);
  endtask

  task automatic t_reset();
    check(req_ready, "R1", "ready after reset", req_ready, 1);
    check(!resp_valid, "R1", "no response after reset", resp_valid, 0);
  endtask

  task automatic t_migration();
    access("R1_R8", mk(1, 0), 0, 0, 0, 0, 3, 32'h0);          // cold miss into far way
    access("R9", mk(1, 0), 1, 32'h11, 0, 1, 3, 32'h11);       // write hit in way 3
    access("R6", mk(1, 0), 0, 0, 0, 1, 2, 32'h11);            // moved one step in
    access("R6", mk(1, 0), 0, 0, 0, 1, 1, 32'h11);
    access("R5", mk(1, 0), 0, 0, 0, 1, 0, 32'h11);
    access("R7", mk(1, 0), 0, 0, 0, 1, 0, 32'h11);            // stays at way 0
  endtask

  task automatic t_write_evict();
    access("R9", mk(2, 0), 1, 32'h22, 0, 0, 3, 32'h22);       // write miss
    access("R5", mk(2, 0), 0, 0, 0, 1, 3, 32'h22);
    access("R8", mk(1, 0), 0, 0, 0, 1, 0, 32'h11);            // near line untouched
    access("R8", mk(3, 0), 1, 32'h33, 0, 0, 3, 32'h33);
    access("R8", mk(4, 0), 1, 32'h44, 0, 0, 3, 32'h44);       // evicts tag 3
    access("R8", mk(3, 0), 0, 0, 0, 0, 3, 32'h0);             // tag 3 gone, evicts tag 4
    access("R8", mk(2, 0), 0, 0, 0, 1, 2, 32'h22);            // way 2 kept
    access("R8", mk(4, 0), 0, 0, 0, 0, 3, 32'h0);             // tag 4 gone
  endtask

  task automatic t_displaced();
    access("R9", mk(5, 1), 1, 32'h55, 0, 0, 3, 32'h55);
    access("R6", mk(5, 1), 0, 0, 0, 1, 3, 32'h55);
    access("R9", mk(6, 1), 1, 32'h66, 0, 0, 3, 32'h66);
    access("R6", mk(6, 1), 0, 0, 0, 1, 3, 32'h66);            // trades with tag 5
    access("R6", mk(5, 1), 0, 0, 0, 1, 3, 32'h55);            // displaced line at way 3
    access("R6", mk(6, 1), 0, 0, 0, 1, 3, 32'h66);            // the trade reversed tag 6 outward
  endtask

  task automatic t_static();
    access("R10", mk(5, 2), 1, 32'h77, 1, 0, 1, 32'h77);      // tag 5 -> way 1
    access("R10", mk(5, 2), 0, 0, 1, 1, 1, 32'h77);
    access("R10", mk(5, 2), 0, 0, 1, 1, 1, 32'h77);           // no move
    access("R10", mk(6, 2), 0, 0, 1, 0, 2, 32'h0);            // tag 6 -> way 2
    access("R10", mk(5, 2), 0, 0, 1, 1, 1, 32'h77);
    access("R6", mk(5, 2), 0, 0, 0, 1, 1, 32'h77);            // migrating again
    access("R6", mk(5, 2), 0, 0, 0, 1, 0, 32'h77);
  endtask

  task automatic t_index();
    access("R2", mk(1, 3), 0, 0, 0, 0, 3, 32'h0);             // tag 1 lives only in set 0
    access("R2", mk(1, 0), 0, 0, 0, 1, 0, 32'h11);
  endtask

  task automatic t_busy_ignore();
    access("R11", mk(1, 4), 0, 0, 0, 0, 3, 32'h0, 1'b1, mk(9, 4));
    access("R11", mk(9, 4), 0, 0, 0, 0, 3, 32'h0);            // stray write left no line
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_migration();
    t_write_evict();
    t_displaced();
    t_static();
    t_index();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule